// File: doc/BRIEF.md
# SMBus Slave Command Decoder

This block sits above a byte-level SMBus slave front end. That front end reports a start condition, a stop condition, and each received byte. The first byte after a start is the address byte. The decoder checks it against the device address, and then interprets what follows as a send-byte or write-byte/word transaction. It returns an ACK or NACK decision for every byte, one clock after the byte arrives.

The first byte after a write-direction address is a command code. A code in the RAM range (0x00 to 0xDF) loads a read/block pointer. Any data bytes that follow are written into RAM, starting at that code. A code from 0xF8 to 0xFB, followed by one byte, is the high and low half of an EEPROM address, which the decoder latches. A third byte in that transaction becomes a program request to the EEPROM controller at that address. Code 0xFE requests an erase of the EEPROM page that the latched address falls in. The request is issued as soon as the command byte has been seen.

While the EEPROM controller reports an erase in progress, the decoder refuses the device address. It then ignores the rest of that transaction.

Top module: `smb_cmd_decode`

## Requirements
- R1: After reset, `ackValid`, `ramWe`, `eeProgReq` and `eraseStart` are 0, `rdPtr` is 0x00 and `eeAddr` is 0xF800.
- R2: The first byte after a start is the address byte, with bits [7:1] the device address and bit 0 the direction (0 = write, 1 = read). One cycle after each received byte, `ackValid` is 1 for exactly one cycle, with `ackOk` = 1 for ACK. An address byte whose bits [7:1] differ from `DEV_ADDR` is NACKed, and every later byte of that transaction is NACKed.
- R3: A command byte in 0x00–0xDF is ACKed and loads `rdPtr`. If a stop follows, nothing is written.
- R4: The first data byte after a RAM-range command is ACKed. It produces a one-cycle `ramWe` with `ramAddr` equal to the command and `ramWdata` equal to the byte.
- R5: A second data byte is written to the command + 1. A third data byte is NACKed. A data byte whose target would lie above 0xDF is NACKed and not written.
- R6: A command byte in 0xF8–0xFB is ACKed and forms the high byte of an EEPROM address. The next byte is ACKed and forms the low byte. The full 16-bit address then appears on `eeAddr`, with no program request.
- R7: A third byte in such a transaction is ACKed. It produces a one-cycle `eeProgReq` with `eeData` equal to that byte, at the address just latched. Any further byte is NACKed.
- R8: Command 0xFE is ACKed and produces a one-cycle `eraseStart` in the cycle after the command byte. `erasePage` is bits [9:5] of `eeAddr`. A byte after 0xFE is NACKed.
- R9: While `eraseBusy` is 1, a matching address byte is NACKed. The rest of that transaction is NACKed and changes nothing.
- R10: Any other command byte (0xE0–0xF7, 0xFC, 0xFD, 0xFF) is NACKed. Later bytes of that transaction are NACKed, and `rdPtr` and `eeAddr` are left unchanged.
- R11: A matching read-direction address byte is ACKed and leaves `rdPtr` unchanged. A repeated start ends the current transaction and begins a new address phase.
- R12: At most one of `ramWe`, `eeProgReq` and `eraseStart` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSeen | input | 1 | Start or repeated start pulse from the front end |
| stopSeen | input | 1 | Stop pulse from the front end |
| rxValid | input | 1 | Received-byte strobe |
| rxData | input | 8 | Received byte |
| eraseBusy | input | 1 | EEPROM controller reports erase in progress |
| ackValid | output | 1 | ACK decision valid for the last byte |
| ackOk | output | 1 | 1 = ACK, 0 = NACK |
| rdPtr | output | 8 | RAM pointer for reads and block transfers |
| ramWe | output | 1 | RAM write strobe |
| ramAddr | output | 8 | RAM write address |
| ramWdata | output | 8 | RAM write data |
| eeAddr | output | 16 | Latched EEPROM address |
| eeProgReq | output | 1 | EEPROM program request |
| eeData | output | 8 | EEPROM program data |
| eraseStart | output | 1 | EEPROM page erase request |
| erasePage | output | 5 | Page index to erase |

## Verification
The inline assertions check the following on every cycle:
- an ACK decision appears exactly one cycle after each byte;
- a busy device never ACKs an address byte;
- refused command codes are always NACKed;
- RAM writes never land above 0xDF;
- at most one of the three request strobes fires in a cycle;
- `rdPtr` and `eeAddr` change only when the decoder asks for it.

Only the bench's transaction scenarios can show the rest:
- which address each data byte is written to;
- that word writes stop at the range edge;
- that an EEPROM address is latched without programming;
- which page an erase targets;
- that rejected transactions leave the pointers as they were.

// File: rtl/smb_cmd_pkg.sv
package smb_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_RAMD, S_EELO, S_EED, S_DROP
  } phase_t;

  typedef struct packed {
    logic loadPtr;
    logic ramWr;
    logic loadEeHi;
    logic loadEeLo;
    logic eeProg;
    logic erase;
  } ctlStrobe_t;

endpackage

// File: rtl/smb_cmd_ctrl.sv
module smb_cmd_ctrl
  import smb_cmd_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h34,
  parameter logic [7:0]  RAM_TOP   = 8'hDF,
  parameter logic [7:0]  ERASE_CMD = 8'hFE,
  parameter logic [15:0] EE_BASE   = 16'hF800,
  parameter logic [15:0] EE_LAST   = 16'hFBFF,
  parameter int          MAX_DATA  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       eraseBusy,
  input  logic [7:0] ptr,
  input  logic [1:0] dataIdx,
  output ctlStrobe_t ctl,
  output logic       ackValid,
  output logic       ackOk
);

  localparam logic [7:0] EE_HI_LO = EE_BASE[15:8];
  localparam logic [7:0] EE_HI_HI = EE_LAST[15:8];

  phase_t phase, phaseNxt;
  logic   ackNxt;
  logic   eeHiCmd, ramCmd;
  logic [8:0] ramTarget;

  assign ramCmd    = rxData <= RAM_TOP;
  assign eeHiCmd   = (rxData >= EE_HI_LO) && (rxData <= EE_HI_HI);
  assign ramTarget = {1'b0, ptr} + {7'b0, dataIdx};

  always_comb begin
    phaseNxt = phase;
    ackNxt   = 1'b0;
    ctl      = '0;
    if (startSeen) begin
      phaseNxt = S_ADDR;
    end else if (stopSeen) begin
      phaseNxt = S_IDLE;
    end else if (rxValid) begin
      phaseNxt = S_DROP;
      unique case (phase)
        S_ADDR: begin
          if (rxData[7:1] == DEV_ADDR && !eraseBusy) begin
            ackNxt = 1'b1;
            if (!rxData[0]) phaseNxt = S_CMD;
          end
        end
        S_CMD: begin
          if (ramCmd) begin
            ackNxt = 1'b1; ctl.loadPtr = 1'b1; phaseNxt = S_RAMD;
          end else if (rxData == ERASE_CMD) begin
            ackNxt = 1'b1; ctl.erase = 1'b1;
          end else if (eeHiCmd) begin
            ackNxt = 1'b1; ctl.loadEeHi = 1'b1; phaseNxt = S_EELO;
          end
        end
        S_RAMD: begin
          if (int'(dataIdx) < MAX_DATA && ramTarget <= {1'b0, RAM_TOP}) begin
            ackNxt = 1'b1; ctl.ramWr = 1'b1; phaseNxt = S_RAMD;
          end
        end
        S_EELO: begin
          ackNxt = 1'b1; ctl.loadEeLo = 1'b1; phaseNxt = S_EED;
        end
        S_EED: begin
          ackNxt = 1'b1; ctl.eeProg = 1'b1;
        end
        default: phaseNxt = (phase == S_IDLE) ? S_IDLE : S_DROP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= S_IDLE;
      ackValid <= 1'b0;
      ackOk    <= 1'b0;
    end else begin
      phase    <= phaseNxt;
      ackValid <= rxValid && !startSeen && !stopSeen;
      ackOk    <= ackNxt;
    end
  end

  // R2
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !startSeen && !stopSeen) |=> ackValid);

  // R2
  ack_only_for_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !ackValid);

  // R9
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == S_ADDR && rxValid && !startSeen && !stopSeen && eraseBusy)
      |=> (ackValid && !ackOk));

  // R10
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == S_CMD && rxValid && !startSeen && !stopSeen &&
     rxData > RAM_TOP && rxData != ERASE_CMD && !eeHiCmd) |=> !ackOk);

endmodule

// File: rtl/smb_cmd_dpath.sv
module smb_cmd_dpath
  import smb_cmd_pkg::*;
#(
  parameter logic [7:0]  RAM_TOP   = 8'hDF,
  parameter logic [15:0] EE_BASE   = 16'hF800,
  parameter int          PAGE_BITS = 5,
  parameter int          OFFS_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           ctl,
  input  logic [7:0]           rxData,
  output logic [7:0]           ptr,
  output logic [1:0]           dataIdx,
  output logic                 ramWe,
  output logic [7:0]           ramAddr,
  output logic [7:0]           ramWdata,
  output logic [15:0]          eeAddr,
  output logic                 eeProgReq,
  output logic [7:0]           eeData,
  output logic                 eraseStart,
  output logic [PAGE_BITS-1:0] erasePage
);

  localparam int PAGE_LSB = OFFS_BITS;
  localparam int PAGE_MSB = OFFS_BITS + PAGE_BITS - 1;

  logic [7:0] eeHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr        <= '0;
      dataIdx    <= '0;
      eeHi       <= EE_BASE[15:8];
      eeAddr     <= EE_BASE;
      ramWe      <= 1'b0;
      ramAddr    <= '0;
      ramWdata   <= '0;
      eeProgReq  <= 1'b0;
      eeData     <= '0;
      eraseStart <= 1'b0;
      erasePage  <= '0;
    end else begin
      ramWe      <= ctl.ramWr;
      eeProgReq  <= ctl.eeProg;
      eraseStart <= ctl.erase;
      if (ctl.loadPtr) begin
        ptr     <= rxData;
        dataIdx <= '0;
      end
      if (ctl.ramWr) begin
        ramAddr  <= ptr + {6'b0, dataIdx};
        ramWdata <= rxData;
        dataIdx  <= dataIdx + 2'd1;
      end
      if (ctl.loadEeHi) eeHi <= rxData;
      if (ctl.loadEeLo) eeAddr <= {eeHi, rxData};
      if (ctl.eeProg) eeData <= rxData;
      if (ctl.erase) erasePage <= eeAddr[PAGE_MSB:PAGE_LSB];
    end
  end

  // R5
  ram_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr <= RAM_TOP));

  // R12
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramWe, eeProgReq, eraseStart}));

  // R10
  ptr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadPtr |=> $stable(ptr));

  // R6
  ee_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadEeLo |=> $stable(eeAddr));

endmodule

// File: rtl/smb_cmd_decode.sv
module smb_cmd_decode
  import smb_cmd_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h34,
  parameter logic [7:0]  RAM_TOP   = 8'hDF,
  parameter logic [7:0]  ERASE_CMD = 8'hFE,
  parameter logic [15:0] EE_BASE   = 16'hF800,
  parameter logic [15:0] EE_LAST   = 16'hFBFF,
  parameter int          MAX_DATA  = 2,
  parameter int          PAGE_BITS = 5,
  parameter int          OFFS_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startSeen,
  input  logic                 stopSeen,
  input  logic                 rxValid,
  input  logic [7:0]           rxData,
  input  logic                 eraseBusy,
  output logic                 ackValid,
  output logic                 ackOk,
  output logic [7:0]           rdPtr,
  output logic                 ramWe,
  output logic [7:0]           ramAddr,
  output logic [7:0]           ramWdata,
  output logic [15:0]          eeAddr,
  output logic                 eeProgReq,
  output logic [7:0]           eeData,
  output logic                 eraseStart,
  output logic [PAGE_BITS-1:0] erasePage
);

  ctlStrobe_t ctl;
  logic [1:0] dataIdx;

  smb_cmd_ctrl #(
    .DEV_ADDR(DEV_ADDR), .RAM_TOP(RAM_TOP), .ERASE_CMD(ERASE_CMD),
    .EE_BASE(EE_BASE), .EE_LAST(EE_LAST), .MAX_DATA(MAX_DATA)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .rxValid(rxValid), .rxData(rxData), .eraseBusy(eraseBusy),
    .ptr(rdPtr), .dataIdx(dataIdx), .ctl(ctl),
    .ackValid(ackValid), .ackOk(ackOk)
  );

  smb_cmd_dpath #(
    .RAM_TOP(RAM_TOP), .EE_BASE(EE_BASE),
    .PAGE_BITS(PAGE_BITS), .OFFS_BITS(OFFS_BITS)
  ) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxData(rxData),
    .ptr(rdPtr), .dataIdx(dataIdx),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .eeAddr(eeAddr), .eeProgReq(eeProgReq), .eeData(eeData),
    .eraseStart(eraseStart), .erasePage(erasePage)
  );

endmodule

// File: tb/sim_smb_cmd_decode.sv
`timescale 1ns/1ps
module sim_smb_cmd_decode;

  typedef struct packed {
    logic [1:0]  kind;   // 0 RAM write, 1 program, 2 erase
    logic [15:0] addr;
    logic [7:0]  data;
  } evt_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startSeen = 1'b0, stopSeen = 1'b0, rxValid = 1'b0, eraseBusy = 1'b0;
  logic [7:0] rxData = '0;
  logic ackValid, ackOk, ramWe, eeProgReq, eraseStart;
  logic [7:0] rdPtr, ramAddr, ramWdata, eeData;
  logic [15:0] eeAddr;
  logic [4:0] erasePage;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic ackQ[$];
  string ackTag[$];
  evt_t evQ[$];
  string evTag[$];

  localparam logic [7:0] WR_ADDR = 8'h68;
  localparam logic [7:0] RD_ADDR = 8'h69;

  always #2 clk = ~clk;

  smb_cmd_decode u0 (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .rxValid(rxValid), .rxData(rxData), .eraseBusy(eraseBusy),
    .ackValid(ackValid), .ackOk(ackOk), .rdPtr(rdPtr),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .eeAddr(eeAddr), .eeProgReq(eeProgReq), .eeData(eeData),
    .eraseStart(eraseStart), .erasePage(erasePage)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected items as the design produces them
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (ackValid) begin
        if (ackQ.size() == 0) check("R2 unexpected ack", 1, 0);
        else check(ackTag.pop_front(), {31'b0, ackOk}, {31'b0, ackQ.pop_front()});
      end
      if (ramWe || eeProgReq || eraseStart) begin
        evt_t got;
        got.kind = ramWe ? 2'd0 : (eeProgReq ? 2'd1 : 2'd2);
        got.addr = ramWe ? {8'h00, ramAddr} : (eeProgReq ? eeAddr : {11'b0, erasePage});
        got.data = ramWe ? ramWdata : (eeProgReq ? eeData : 8'h00);
        if (evQ.size() == 0) check("R12 unexpected request", {6'b0, got}, 0);
        else check(evTag.pop_front(), {6'b0, got}, {6'b0, evQ.pop_front()});
      end
    end
  end

  task automatic pulseStart();
    @(negedge clk); startSeen = 1'b1;
    @(negedge clk); startSeen = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopSeen = 1'b1;
    @(negedge clk); stopSeen = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    ackQ.push_back(expAck);
    ackTag.push_back(tag);
    @(negedge clk); rxValid = 1'b1; rxData = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic expectEvt(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d,
                           input string tag);
    evt_t e;
    e.kind = k; e.addr = a; e.data = d;
    evQ.push_back(e);
    evTag.push_back(tag);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      done = 1'b1;
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ackValid", {31'b0, ackValid}, 0);
    check("R1 strobes", {29'b0, ramWe, eeProgReq, eraseStart}, 0);
    check("R1 rdPtr", {24'b0, rdPtr}, 32'h00);
    check("R1 eeAddr", {16'b0, eeAddr}, 32'hF800);
    rstN = 1'b1;
    settle();

    // R3 send-byte loads pointer only
    pulseStart();
    sendByte(WR_ADDR, 1, "R2 address ACK");
    sendByte(8'h10, 1, "R3 RAM command ACK");
    pulseStop(); settle();
    check("R3 rdPtr after send-byte", {24'b0, rdPtr}, 32'h10);

    // R2 foreign address
    pulseStart();
    sendByte(8'h50, 0, "R2 foreign address NACK");
    sendByte(8'h22, 0, "R2 later byte NACK");
    pulseStop(); settle();
    check("R2 rdPtr untouched", {24'b0, rdPtr}, 32'h10);

    // R4 write-byte
    pulseStart();
    sendByte(WR_ADDR, 1, "R2 address ACK");
    sendByte(8'h20, 1, "R4 command ACK");
    expectEvt(0, 16'h0020, 8'hA5, "R4 RAM write");
    sendByte(8'hA5, 1, "R4 data ACK");
    pulseStop(); settle();
    check("R4 rdPtr", {24'b0, rdPtr}, 32'h20);

    // R5 write-word and third byte
    pulseStart();
    sendByte(WR_ADDR, 1, "R2 address ACK");
    sendByte(8'h30, 1, "R5 command ACK");
    expectEvt(0, 16'h0030, 8'hA1, "R5 first word byte");
    sendByte(8'hA1, 1, "R5 first data ACK");
    expectEvt(0, 16'h0031, 8'hB2, "R5 second word byte");
    sendByte(8'hB2, 1, "R5 second data ACK");
    sendByte(8'hC3, 0, "R5 third data NACK");
    pulseStop(); settle();

    // R5 top-of-range
    pulseStart();
    sendByte(WR_ADDR, 1, "R2 address ACK");
    sendByte(8'hDF, 1, "R5 top command ACK");
    expectEvt(0, 16'h00DF, 8'h11, "R5 write at top");
    sendByte(8'h11, 1, "R5 top data ACK");
    sendByte(8'h12, 0, "R5 past-top NACK");
    pulseStop(); settle();

    // R10 invalid command
    pulseStart();
    sendByte(WR_ADDR, 1, "R2 address ACK");
    sendByte(8'hE5, 0, "R10 invalid command NACK");
    sendByte(8'h33, 0, "R10 following byte NACK");
    pulseStop(); settle();
    check("R10 rdPtr unchanged", {24'b0, rdPtr}, 32'hDF);
    check("R10 eeAddr unchanged", {16'b0, eeAddr}, 32'hF800);

    // R6 EEPROM address latch
    pulseStart();
    sendByte(WR_ADDR, 1, "R2 address ACK");
    sendByte(8'hF9, 1, "R6 high byte ACK");
    sendByte(8'h47, 1, "R6 low byte ACK");
    pulseStop(); settle();
    check("R6 eeAddr latched", {16'b0, eeAddr}, 32'hF947);

    // R7 program request
    pulseStart();
    sendByte(WR_ADDR, 1, "R2 address ACK");
    sendByte(8'hFA, 1, "R7 high byte ACK");
    sendByte(8'h21, 1, "R7 low byte ACK");
    expectEvt(1, 16'hFA21, 8'h5C, "R7 program request");
    sendByte(8'h5C, 1, "R7 data ACK");
    sendByte(8'h5D, 0, "R7 extra byte NACK");
    pulseStop(); settle();

    // R8 erase: page = (0xFA21 bits 9:5) = 17
    pulseStart();
    sendByte(WR_ADDR, 1, "R2 address ACK");
    expectEvt(2, 16'd17, 8'h00, "R8 erase page");
    sendByte(8'hFE, 1, "R8 erase command ACK");
    sendByte(8'h00, 0, "R8 byte after erase NACK");
    pulseStop(); settle();

    // R9 busy
    eraseBusy = 1'b1;
    pulseStart();
    sendByte(WR_ADDR, 0, "R9 busy address NACK");
    sendByte(8'h40, 0, "R9 busy command NACK");
    sendByte(8'h77, 0, "R9 busy data NACK");
    pulseStop(); settle();
    check("R9 rdPtr unchanged", {24'b0, rdPtr}, 32'hDF);
    eraseBusy = 1'b0;

    // R11 read direction and repeated start
    pulseStart();
    sendByte(WR_ADDR, 1, "R2 address ACK");
    sendByte(8'h07, 1, "R3 command ACK");
    pulseStart();
    sendByte(RD_ADDR, 1, "R11 read address ACK");
    pulseStop(); settle();
    check("R11 rdPtr after read start", {24'b0, rdPtr}, 32'h07);

    settle();
    check("R2 all ACKs seen", ackQ.size(), 0);
    check("R12 all requests seen", evQ.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule